// File: doc/BRIEF.md
# Indirect Data Memory Addressing Unit

This block keeps three 12-bit pointers into a 4096-byte data memory. Each pointer is loaded through two byte writes: a low byte that sets bits 7:0 and a high byte of which only the low four bits are kept, as bits 11:8. Software reaches memory through five virtual operand registers for each pointer. A read or write strobe on one of them turns into a data-memory address in the same cycle. At the next clock edge the pointer is then updated as that alias asks.

The five aliases give plain access, post-increment, post-decrement, pre-increment, and access at the pointer plus the working register taken as a signed byte. The aliases have no storage of their own. If an effective address falls on an alias location, the access is a null access: it reads as zero, drives no memory enable and changes no pointer. Every access finishes in one cycle and the unit never stalls, so it has no valid/ready handshake. The strobes and pointer byte writes are plain one-cycle control pins that are always accepted.

Top module: `ind_addr_unit`

## Requirements
- R1: While reset is held and after it is released, all three pointers read zero on `ptr_all`. With no strobe applied, `mem_en` and `mem_null` are low.
- R2: A pointer byte write with `pw_hi`=0 loads bits 7:0 from `pw_data`. With `pw_hi`=1 it loads bits 11:8 from `pw_data[3:0]` and discards `pw_data[7:4]`. The other byte keeps its value. The result shows on `ptr_all` (pointer n at bits 12n+11:12n) from the next cycle.
- R3: Mode code 0 (plain) drives `mem_addr` with the pointer value in the same cycle and leaves the pointer unchanged.
- R4: Mode code 1 (post-increment) drives `mem_addr` with the current pointer value, and the pointer is one higher after the edge.
- R5: Mode code 2 (post-decrement) drives `mem_addr` with the current pointer value, and the pointer is one lower after the edge.
- R6: Mode code 3 (pre-increment) drives `mem_addr` with pointer+1 in the same cycle, and that value becomes the pointer after the edge.
- R7: Mode code 4 (indexed) drives `mem_addr` with the pointer plus `wreg` taken as a signed 8-bit value, and leaves the pointer unchanged.
- R8: All pointer and address arithmetic wraps modulo 4096. Carries and borrows cross between the low and high bytes, so FFF+1 gives 000 and 000-1 gives FFF.
- R9: A byte write to the same pointer in the same cycle as a modifying access wins. The written byte is loaded, the other byte keeps its pre-cycle value, and the auto-modify is dropped.
- R10: The alias of pointer p with mode m sits at address FE0 + 8p + m, for m = 0 to 4. If the effective address hits one of these, `mem_null` is high, `mem_en` is low and no pointer changes. Addresses in the gaps, such as FE5, are ordinary memory.
- R11: No access happens for pointer code 3, for mode codes 5 to 7, or when neither `acc_rd` nor `acc_wr` is high. In these cases `mem_en` and `mem_null` stay low and no pointer changes.
- R12: An access through one pointer never changes the other two pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read strobe on a virtual alias |
| acc_wr | input | 1 | Write strobe on a virtual alias |
| acc_ptr | input | 2 | Pointer code of the alias, 0 to 2 |
| acc_mode | input | 3 | Alias mode code: 0 plain, 1 post-increment, 2 post-decrement, 3 pre-increment, 4 indexed |
| wreg | input | 8 | Working-register value, the signed offset for indexed access |
| pw_en | input | 1 | Pointer byte write enable |
| pw_ptr | input | 2 | Pointer receiving the byte write |
| pw_hi | input | 1 | 1 writes the high byte, 0 writes the low byte |
| pw_data | input | 8 | Byte written to the pointer |
| mem_addr | output | 12 | Effective data-memory address, zero when there is no access |
| mem_en | output | 1 | A real memory access is taking place this cycle |
| mem_null | output | 1 | The access hit an alias location: it reads as zero and has no effect |
| ptr_all | output | 36 | The three pointer values, pointer n at bits 12n+11:12n |

## Verification
`mem_addr`, `mem_en` and `mem_null` are combinational from the strobe inputs and the stored pointers. The bench therefore samples them 2 ns after it drives an access at the falling edge, before the rising edge consumes the access. Pointer updates from an alias access, and pointer byte writes, show on `ptr_all` only after that rising edge. So every pointer check samples at the following falling edge, one cycle after the stimulus. Stored memory data, written at the rising edge, is read back in a later access cycle.

// File: rtl/iau_pkg.sv
package iau_pkg;
  typedef enum logic [2:0] {
    M_PLAIN   = 3'd0,
    M_POSTINC = 3'd1,
    M_POSTDEC = 3'd2,
    M_PREINC  = 3'd3,
    M_INDEX   = 3'd4
  } amode_e;

  localparam int NMODES       = 5;
  localparam int ALIAS_STRIDE = 8;
endpackage

// File: rtl/iau_ptr_reg.sv
module iau_ptr_reg #(
  parameter int AW = 12,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_val,
  input  logic          bw_en,
  input  logic          bw_hi,
  input  logic [LW-1:0] bw_data,
  output logic [AW-1:0] q
);
  localparam int HW = AW - LW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (bw_en) begin
      // a direct byte write overrides any auto-modify in the same cycle
      if (bw_hi) q[AW-1:LW] <= bw_data[HW-1:0];
      else       q[LW-1:0]  <= bw_data;
    end else if (upd_en) begin
      q <= upd_val;
    end
  end
endmodule

// File: rtl/iau_addr_gen.sv
module iau_addr_gen
  import iau_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 8
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    mode,
  input  logic [LW-1:0] wreg,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] nxt,
  output logic          moves
);
  logic [AW-1:0] inc_v, dec_v, idx_v;

  always_comb begin
    inc_v = cur + AW'(1);
    dec_v = cur - AW'(1);
    idx_v = cur + {{(AW-LW){wreg[LW-1]}}, wreg};
    ea    = cur;
    nxt   = cur;
    moves = 1'b0;
    case (mode)
      M_POSTINC: begin nxt = inc_v; moves = 1'b1; end
      M_POSTDEC: begin nxt = dec_v; moves = 1'b1; end
      M_PREINC:  begin ea = inc_v; nxt = inc_v; moves = 1'b1; end
      M_INDEX:   ea = idx_v;
      default:   ;
    endcase
  end
endmodule

// File: rtl/iau_alias_dec.sv
module iau_alias_dec
  import iau_pkg::*;
#(
  parameter int            AW   = 12,
  parameter int            NPTR = 3,
  parameter logic [AW-1:0] BASE = 12'hFE0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] WIN = AW'(NPTR * ALIAS_STRIDE);
  localparam int            SW  = $clog2(ALIAS_STRIDE);

  logic [AW-1:0] off;

  always_comb begin
    off = addr - BASE;
    hit = (off < WIN) && (int'(off[SW-1:0]) < NMODES);
  end
endmodule

// File: rtl/ind_addr_unit.sv
module ind_addr_unit
  import iau_pkg::*;
#(
  parameter int            NPTR       = 3,
  parameter int            AW         = 12,
  parameter int            LW         = 8,
  parameter logic [AW-1:0] ALIAS_BASE = 12'hFE0,
  localparam int           PW         = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic [PW-1:0]      acc_ptr,
  input  logic [2:0]         acc_mode,
  input  logic [LW-1:0]      wreg,
  input  logic               pw_en,
  input  logic [PW-1:0]      pw_ptr,
  input  logic               pw_hi,
  input  logic [LW-1:0]      pw_data,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_en,
  output logic               mem_null,
  output logic [NPTR*AW-1:0] ptr_all
);
  logic [AW-1:0] ptr_q [NPTR];
  logic [AW-1:0] cur, ea, nxt;
  logic          moves, hit, sel_ok, upd_ok;

  always_comb begin
    cur = '0;
    for (int i = 0; i < NPTR; i++)
      if (int'(acc_ptr) == i) cur = ptr_q[i];
  end

  assign sel_ok = (acc_rd | acc_wr) && (int'(acc_ptr) < NPTR)
                  && (int'(acc_mode) < NMODES);

  iau_addr_gen #(.AW(AW), .LW(LW)) u_gen (
    .cur   (cur),
    .mode  (acc_mode),
    .wreg  (wreg),
    .ea    (ea),
    .nxt   (nxt),
    .moves (moves)
  );

  iau_alias_dec #(.AW(AW), .NPTR(NPTR), .BASE(ALIAS_BASE)) u_dec (
    .addr (ea),
    .hit  (hit)
  );

  assign mem_addr = sel_ok ? ea : '0;
  assign mem_en   = sel_ok & ~hit;
  assign mem_null = sel_ok & hit;
  assign upd_ok   = mem_en & moves;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    iau_ptr_reg #(.AW(AW), .LW(LW)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (upd_ok && (int'(acc_ptr) == g)),
      .upd_val (nxt),
      .bw_en   (pw_en && (int'(pw_ptr) == g)),
      .bw_hi   (pw_hi),
      .bw_data (pw_data),
      .q       (ptr_q[g])
    );
    assign ptr_all[g*AW +: AW] = ptr_q[g];
  end
endmodule

// File: rtl/ind_addr_unit_chk.sv
module ind_addr_unit_chk #(
  parameter int NPTR = 3,
  parameter int AW   = 12,
  parameter int LW   = 8,
  parameter int PW   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_rd,
  input logic               acc_wr,
  input logic [PW-1:0]      acc_ptr,
  input logic [2:0]         acc_mode,
  input logic               pw_en,
  input logic [PW-1:0]      pw_ptr,
  input logic               pw_hi,
  input logic [LW-1:0]      pw_data,
  input logic [AW-1:0]      mem_addr,
  input logic               mem_en,
  input logic               mem_null,
  input logic [NPTR*AW-1:0] ptr_all
);
  logic [PW-1:0] aidx_q, widx_q;
  logic [AW-1:0] cur, acc_now, pw_now;
  logic          sel_ok, collide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aidx_q <= '0;
      widx_q <= '0;
    end else begin
      aidx_q <= acc_ptr;
      widx_q <= pw_ptr;
    end
  end

  assign cur     = AW'(ptr_all >> (int'(acc_ptr) * AW));
  assign acc_now = AW'(ptr_all >> (int'(aidx_q) * AW));
  assign pw_now  = AW'(ptr_all >> (int'(widx_q) * AW));
  assign sel_ok  = (acc_rd | acc_wr) && (int'(acc_ptr) < NPTR) && (acc_mode < 3'd5);
  assign collide = pw_en && (pw_ptr == acc_ptr);

  // R3
  plain_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && acc_mode == 3'd0 && !collide) |=> acc_now == $past(cur));
  // R4
  postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && acc_mode == 3'd1 && !collide) |=> acc_now == AW'($past(cur) + AW'(1)));
  // R5
  postdec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && acc_mode == 3'd2 && !collide) |=> acc_now == AW'($past(cur) - AW'(1)));
  // R6
  preinc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && acc_mode == 3'd3 && !collide) |=> acc_now == $past(mem_addr));
  // R7
  index_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && acc_mode == 3'd4 && !collide) |=> acc_now == $past(cur));
  // R10
  null_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_null && !collide) |=> acc_now == $past(cur));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> (!mem_en && !mem_null));
  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en && !pw_hi && sel_ok && collide) |=>
      (acc_now[LW-1:0] == $past(pw_data) && acc_now[AW-1:LW] == $past(cur[AW-1:LW])));
  // R2
  high_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en && pw_hi) |=> pw_now[AW-1:LW] == $past(pw_data[AW-LW-1:0]));
endmodule

bind ind_addr_unit ind_addr_unit_chk #(.NPTR(NPTR), .AW(AW), .LW(LW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_rd   (acc_rd),
  .acc_wr   (acc_wr),
  .acc_ptr  (acc_ptr),
  .acc_mode (acc_mode),
  .pw_en    (pw_en),
  .pw_ptr   (pw_ptr),
  .pw_hi    (pw_hi),
  .pw_data  (pw_data),
  .mem_addr (mem_addr),
  .mem_en   (mem_en),
  .mem_null (mem_null),
  .ptr_all  (ptr_all)
);

// File: tb/test_ind_addr_unit.sv
`timescale 1ns/1ps
module test_ind_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_ptr = '0;
  logic [2:0]  acc_mode = '0;
  logic [7:0]  wreg = '0;
  logic        pw_en = 1'b0, pw_hi = 1'b0;
  logic [1:0]  pw_ptr = '0;
  logic [7:0]  pw_data = '0;
  logic [11:0] mem_addr;
  logic        mem_en, mem_null;
  logic [35:0] ptr_all;

  int total = 0;
  int bad   = 0;
  logic [7:0]  mem [4096];
  logic [7:0]  wdat = '0;
  logic [11:0] s_addr;
  logic        s_en, s_null;
  logic [7:0]  s_rdat;

  always #10 clk = ~clk;

  ind_addr_unit i_ind_addr_unit (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_ptr(acc_ptr), .acc_mode(acc_mode), .wreg(wreg),
    .pw_en(pw_en), .pw_ptr(pw_ptr), .pw_hi(pw_hi), .pw_data(pw_data),
    .mem_addr(mem_addr), .mem_en(mem_en), .mem_null(mem_null), .ptr_all(ptr_all)
  );

  always @(posedge clk) if (acc_wr && mem_en) mem[mem_addr] <= wdat;

  // ptr, mode, wreg, expected address, expected pointer after the edge
  localparam logic [36:0] VEC [10] = '{
    {2'd0, 3'd0, 8'h00, 12'h123, 12'h123},  // R3
    {2'd0, 3'd1, 8'h00, 12'h123, 12'h124},  // R4
    {2'd0, 3'd2, 8'h00, 12'h124, 12'h123},  // R5
    {2'd0, 3'd3, 8'h00, 12'h124, 12'h124},  // R6
    {2'd0, 3'd4, 8'h10, 12'h134, 12'h124},  // R7 positive
    {2'd0, 3'd4, 8'hF0, 12'h114, 12'h124},  // R7 negative
    {2'd1, 3'd1, 8'h00, 12'h0FF, 12'h100},  // R8 carry
    {2'd1, 3'd2, 8'h00, 12'h100, 12'h0FF},  // R8 borrow
    {2'd2, 3'd3, 8'h00, 12'h801, 12'h801},  // R6
    {2'd2, 3'd2, 8'h00, 12'h801, 12'h800}   // R5
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ptr_of(input int p);
    return ptr_all[p*12 +: 12];
  endfunction

  // one cycle: drive at falling edge, sample combinational outputs, pass the rising edge
  task automatic cyc(input logic rd, input logic wr, input logic [1:0] p, input logic [2:0] m,
                     input logic [7:0] w, input logic pe, input logic [1:0] pp,
                     input logic ph, input logic [7:0] pd);
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_ptr = p; acc_mode = m; wreg = w;
    pw_en = pe; pw_ptr = pp; pw_hi = ph; pw_data = pd;
    #2;
    s_addr = mem_addr; s_en = mem_en; s_null = mem_null;
    s_rdat = mem_null ? 8'h00 : mem[mem_addr];
    @(posedge clk);
    #1;
    acc_rd = 1'b0; acc_wr = 1'b0; pw_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic setp(input logic [1:0] p, input logic [11:0] v);
    cyc(0, 0, 0, 0, 0, 1, p, 1, {4'h0, v[11:8]});
    cyc(0, 0, 0, 0, 0, 1, p, 0, v[7:0]);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ptrs", ptr_all, 36'h0);
    chk("R1 idle", {34'h0, mem_en, mem_null}, 36'h0);

    cyc(0, 0, 0, 0, 0, 1, 1, 1, 8'hAB);
    chk("R2 hi", {24'h0, ptr_of(1)}, 36'hB00);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 8'hCD);
    chk("R2 lo", {24'h0, ptr_of(1)}, 36'hBCD);
    chk("R12 others", {12'h0, ptr_of(2), ptr_of(0)}, 36'h0);

    setp(0, 12'h123); setp(1, 12'h0FF); setp(2, 12'h800);
    for (int i = 0; i < 10; i++) begin
      cyc(1, 0, VEC[i][36:35], VEC[i][34:32], VEC[i][31:24], 0, 0, 0, 0);
      chk($sformatf("R3-7 row%0d addr", i), {23'h0, s_en, s_addr}, {23'h0, 1'b1, VEC[i][23:12]});
      chk($sformatf("R3-7 row%0d ptr", i), {24'h0, ptr_of(int'(VEC[i][36:35]))}, {24'h0, VEC[i][11:0]});
    end
    chk("R12 all", ptr_all, {12'h800, 12'h0FF, 12'h124});

    setp(0, 12'hFFF);
    cyc(1, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R8 inc addr", {24'h0, s_addr}, 36'hFFF);
    chk("R8 inc wrap", {24'h0, ptr_of(0)}, 36'h000);
    cyc(1, 0, 0, 2, 0, 0, 0, 0, 0);
    chk("R8 dec wrap", {24'h0, ptr_of(0)}, 36'hFFF);
    setp(0, 12'h005);
    cyc(1, 0, 0, 4, 8'hF0, 0, 0, 0, 0);
    chk("R7 R8 index wrap", {24'h0, s_addr}, 36'hFF5);

    setp(0, 12'hFE8);
    cyc(1, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R10 null flags", {34'h0, s_en, s_null}, 36'h1);
    chk("R10 no change", {24'h0, ptr_of(0)}, 36'hFE8);
    chk("R10 reads zero", {28'h0, s_rdat}, 36'h0);
    setp(0, 12'hFE7);
    cyc(1, 0, 0, 3, 0, 0, 0, 0, 0);
    chk("R10 preinc null", {23'h0, s_null, ptr_of(0)}, {23'h0, 1'b1, 12'hFE7});
    setp(0, 12'hFE5);
    cyc(1, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R10 gap is memory", {23'h0, s_en, ptr_of(0)}, {23'h0, 1'b1, 12'hFE6});

    setp(1, 12'h0FF);
    cyc(1, 0, 1, 1, 0, 1, 1, 0, 8'h40);
    chk("R9 write wins", {24'h0, ptr_of(1)}, 36'h040);

    cyc(1, 0, 1, 5, 0, 0, 0, 0, 0);
    chk("R11 bad mode", {23'h0, s_en | s_null, ptr_of(1)}, {24'h0, 12'h040});
    cyc(1, 1, 3, 1, 0, 0, 0, 0, 0);
    chk("R11 bad ptr", {22'h0, s_en, s_null, ptr_all[11:0]}, {24'h0, 12'hFE6});
    cyc(0, 0, 1, 1, 0, 0, 0, 0, 0);
    chk("R11 no strobe", {23'h0, s_en, ptr_of(1)}, {24'h0, 12'h040});

    setp(2, 12'h300);
    wdat = 8'h11; cyc(0, 1, 2, 1, 0, 0, 0, 0, 0);
    wdat = 8'h22; cyc(0, 1, 2, 1, 0, 0, 0, 0, 0);
    wdat = 8'h33; cyc(0, 1, 2, 1, 0, 0, 0, 0, 0);
    chk("R4 stream ptr", {24'h0, ptr_of(2)}, 36'h303);
    setp(2, 12'h300);
    cyc(1, 0, 2, 1, 0, 0, 0, 0, 0);
    chk("R4 stream rd0", {28'h0, s_rdat}, 36'h11);
    cyc(1, 0, 2, 1, 0, 0, 0, 0, 0);
    chk("R4 stream rd1", {28'h0, s_rdat}, 36'h22);
    cyc(1, 0, 2, 1, 0, 0, 0, 0, 0);
    chk("R4 stream rd2", {28'h0, s_rdat}, 36'h33);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset again", ptr_all, 36'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule